// File: doc/BRIEF.md
# Audio FSK Bit Recovery with Delay Discriminator and Phase Tracker

This block turns a stream of signed 8-bit audio samples into recovered data bits. The samples carry a two-tone frequency-shift-keyed signal at a fixed rate of eight samples per bit. Each sample is multiplied by the sample taken half a bit earlier. The sign of that product, once smoothed, follows which of the two tones is present. A low-pass filter built only from shifts and adds removes the double-frequency ripple. The filter output is then sliced to one bit per sample.

Bit timing comes from a phase accumulator. It advances a fixed step on every sample, and each transition in the sliced stream pulls it a little toward the middle of its range. Whenever the accumulator wraps, a 2-of-3 vote over the newest sliced bits gives a raw decision. The output bit is that decision decoded from transition coding: a change between two consecutive decisions means 0, and no change means 1.

A sample is presented by raising a one-cycle strobe together with the sample value. The recovered bit appears with its own one-cycle strobe on the clock after the sample that caused the wrap.

Top module: `afsk_bit_recovery`

## Requirements
- R1: While reset is held low and after its release, `bit_vld` and `bit_out` are 0. The delay line, filter state, sliced-bit history, phase and decision history are all cleared.
- R2: The delay line holds 4 samples (SPB/2) and starts at zero. The product formed for sample n uses sample n-4, so the first four products after reset are zero.
- R3: The product is the signed 16-bit result shifted arithmetically right by 2, giving x[n]. The filter computes y[n] = x[n] + x[n-1] + (y[n-1]>>>1) + (y[n-1]>>>3) + (y[n-1]>>>5) in an 18-bit signed state.
- R4: The sliced bit for a sample is 1 only when y[n] is strictly greater than zero. A zero output slices to 0.
- R5: Without transitions, the phase accumulator gains 8 on each accepted sample and wraps modulo 64. Each wrap produces exactly one `bit_vld` pulse, so a silent input yields a strobe on every 8th sample, starting with the 8th after reset.
- R6: When the two newest sliced bits differ, the phase is first raised by 1 if it is below 32, or lowered by 1 otherwise. The advance of 8 is applied after this correction.
- R7: At a wrap, the raw decision is 1 when at least two of the three newest sliced bits (including the current one) are 1.
- R8: `bit_out` is 1 when the current and previous raw decisions are equal and 0 when they differ. The previous decision is 0 right after reset.
- R9: A clock cycle with `smp_vld` low changes no state. `bit_vld` pulses only in the cycle after an accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_in | input | 8 | Signed audio sample |
| bit_vld | output | 1 | One-cycle strobe marking a recovered bit |
| bit_out | output | 1 | Recovered, transition-decoded bit |

## Verification
Four kinds of input are used.

- An all-zero input exercises the free-running phase and the strictly-positive slice threshold. It must give a strobe exactly on sample 8 and an output of 1.
- A constant positive input tells whether the delay is really half a bit. Its single transition arrives on sample 5 with the phase at 32, and the resulting downward nudge moves the first strobe to sample 9. A missing delay would leave the strobe on sample 8. The two decisions that follow, a change and then no change, expose the decoding in both directions.
- A mixed-tone waveform is run forward, sign-inverted and reversed, and compared sample by sample with a behavioural model of the filter, nudge and vote.
- Idle cycles are inserted between samples to show that nothing moves without a strobe.

// File: rtl/afsk_demod_pkg.sv
package afsk_demod_pkg;

   // Returns 1 when at least half (rounded up) of the lowest n bits are set.
   function automatic logic vote_major(input logic [7:0] bits, input int n);
      int cnt;
      cnt = 0;
      for (int i = 0; i < 8; i++) begin
         if (i < n && bits[i]) cnt++;
      end
      return (cnt >= (n + 1) / 2);
   endfunction

   // Transition decoding: equal neighbours give 1, a change gives 0.
   function automatic logic nrzi_bit(input logic [1:0] pair);
      return (pair[1] == pair[0]);
   endfunction

endpackage

// File: rtl/afsk_delay_mult.sv
module afsk_delay_mult #(
   parameter int SAMPLE_W   = 8,
   parameter int DELAY      = 4,
   parameter int PROD_SHIFT = 2,
   parameter int PROD_W     = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic signed [SAMPLE_W-1:0] smp,
   output logic signed [PROD_W-1:0]   prod
);

   localparam int FULL_W = 2 * SAMPLE_W;

   logic signed [SAMPLE_W-1:0] line_q [DELAY];
   logic signed [SAMPLE_W-1:0] tail;
   logic signed [FULL_W-1:0]   full;
   logic signed [FULL_W-1:0]   scaled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DELAY; i++) line_q[i] <= '0;
      end else if (en) begin
         line_q[0] <= smp;
         for (int i = 1; i < DELAY; i++) line_q[i] <= line_q[i-1];
      end
   end

   assign tail   = line_q[DELAY-1];
   assign full   = tail * smp;
   assign scaled = full >>> PROD_SHIFT;
   assign prod   = PROD_W'(scaled);

endmodule

// File: rtl/afsk_shift_iir.sv
module afsk_shift_iir #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 18,
   parameter int NTAP  = 3,
   parameter int FB_SH [NTAP] = '{1, 3, 5}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [IN_W-1:0]  x_in,
   output logic signed [ACC_W-1:0] y_now
);

   logic signed [IN_W-1:0]  x_q;
   logic signed [ACC_W-1:0] y_q;
   logic signed [ACC_W-1:0] fb_term [NTAP];

   // one arithmetic-shift feedback term per tap
   for (genvar k = 0; k < NTAP; k++) begin : g_fb
      assign fb_term[k] = y_q >>> FB_SH[k];
   end

   always_comb begin
      y_now = ACC_W'(x_in) + ACC_W'(x_q);
      for (int k = 0; k < NTAP; k++) y_now = y_now + fb_term[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (en) begin
         x_q <= x_in;
         y_q <= y_now;
      end
   end

endmodule

// File: rtl/afsk_bit_dpll.sv
module afsk_bit_dpll
   import afsk_demod_pkg::*;
#(
   parameter int SPB        = 8,
   parameter int PHASE_STEP = 8,
   parameter int NUDGE      = 1,
   parameter int VOTE_N     = 3,
   parameter int PH_W       = $clog2(SPB * PHASE_STEP) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            slice,
   output logic            bit_vld,
   output logic            bit_out,
   output logic [PH_W-1:0] phase
);

   localparam int PHASE_MAX = SPB * PHASE_STEP;
   localparam int PHASE_THR = PHASE_MAX / 2;

   logic [VOTE_N-1:0] hist_q, hist_n;
   logic [PH_W-1:0]   phase_q, ph_adj, ph_sum, ph_nxt;
   logic [1:0]        found_q, found_n;
   logic              edge_w, wrap, decision;

   assign hist_n = {hist_q[VOTE_N-2:0], slice};
   assign edge_w = hist_n[1] ^ hist_n[0];

   always_comb begin
      ph_adj = phase_q;
      if (edge_w) begin
         if (phase_q < PH_W'(PHASE_THR)) ph_adj = phase_q + PH_W'(NUDGE);
         else                            ph_adj = phase_q - PH_W'(NUDGE);
      end
      ph_sum = ph_adj + PH_W'(PHASE_STEP);
      wrap   = (ph_sum >= PH_W'(PHASE_MAX));
      ph_nxt = wrap ? ph_sum - PH_W'(PHASE_MAX) : ph_sum;
   end

   assign decision = vote_major(8'(hist_n), VOTE_N);
   assign found_n  = {found_q[0], decision};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         phase_q <= '0;
         found_q <= '0;
         bit_vld <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         bit_vld <= en && wrap;
         if (en) begin
            hist_q  <= hist_n;
            phase_q <= ph_nxt;
            if (wrap) begin
               found_q <= found_n;
               bit_out <= nrzi_bit(found_n);
            end
         end
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/afsk_bit_recovery.sv
module afsk_bit_recovery #(
   parameter int SAMPLE_W   = 8,
   parameter int SPB        = 8,
   parameter int PHASE_STEP = 8,
   parameter int NUDGE      = 1,
   parameter int VOTE_N     = 3,
   parameter int PROD_SHIFT = 2,
   parameter int PROD_W     = 16,
   parameter int ACC_W      = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_in,
   output logic                bit_vld,
   output logic                bit_out
);

   localparam int DELAY     = SPB / 2;
   localparam int PHASE_MAX = SPB * PHASE_STEP;
   localparam int PH_W      = $clog2(PHASE_MAX) + 1;

   initial begin : p_param_chk
      assert (SPB >= 2 && SPB % 2 == 0)
         else $fatal(1, "SPB must be even and at least 2");
      assert (PROD_W >= 2 * SAMPLE_W)
         else $fatal(1, "PROD_W too narrow for the product");
      assert (ACC_W > PROD_W)
         else $fatal(1, "ACC_W must exceed PROD_W");
      assert (VOTE_N >= 3 && VOTE_N <= 8 && VOTE_N % 2 == 1)
         else $fatal(1, "VOTE_N must be odd, 3..8");
      assert (NUDGE < PHASE_STEP)
         else $fatal(1, "NUDGE must be smaller than PHASE_STEP");
   end

   logic signed [PROD_W-1:0] prod_w;
   logic signed [ACC_W-1:0]  filt_w;
   logic                     slice_w;
   logic [PH_W-1:0]          phase_w;

   afsk_delay_mult #(
      .SAMPLE_W(SAMPLE_W), .DELAY(DELAY), .PROD_SHIFT(PROD_SHIFT), .PROD_W(PROD_W)
   ) u_disc (
      .clk(clk), .rst_n(rst_n), .en(smp_vld),
      .smp($signed(smp_in)), .prod(prod_w)
   );

   afsk_shift_iir #(
      .IN_W(PROD_W), .ACC_W(ACC_W)
   ) u_lpf (
      .clk(clk), .rst_n(rst_n), .en(smp_vld),
      .x_in(prod_w), .y_now(filt_w)
   );

   assign slice_w = (filt_w > 0);

   afsk_bit_dpll #(
      .SPB(SPB), .PHASE_STEP(PHASE_STEP), .NUDGE(NUDGE), .VOTE_N(VOTE_N), .PH_W(PH_W)
   ) u_dpll (
      .clk(clk), .rst_n(rst_n), .en(smp_vld), .slice(slice_w),
      .bit_vld(bit_vld), .bit_out(bit_out), .phase(phase_w)
   );

endmodule

// File: rtl/afsk_bit_recovery_chk.sv
module afsk_bit_recovery_chk #(
   parameter int PH_W       = 7,
   parameter int PHASE_MAX  = 64,
   parameter int PHASE_STEP = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            smp_vld,
   input logic            bit_vld,
   input logic            bit_out,
   input logic [PH_W-1:0] phase
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (phase == '0 && !bit_vld && !bit_out));

   // R5
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase < PH_W'(PHASE_MAX));

   // R5
   wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> phase < PH_W'(PHASE_STEP));

   // R9
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> !bit_vld);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(phase) && $stable(bit_out)));

endmodule

bind afsk_bit_recovery afsk_bit_recovery_chk #(
   .PH_W(PH_W), .PHASE_MAX(PHASE_MAX), .PHASE_STEP(PHASE_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
   .bit_vld(bit_vld), .bit_out(bit_out), .phase(phase_w)
);

// File: tb/afsk_bit_recovery_tb.sv
module afsk_bit_recovery_tb;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_vld = 1'b0;
   logic signed [7:0] smp_in = '0;
   logic              bit_vld;
   logic              bit_out;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   afsk_bit_recovery u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
      .bit_vld(bit_vld), .bit_out(bit_out)
   );

   localparam int TAB_N = 32;
   localparam logic signed [7:0] WALK_TAB [TAB_N] = '{
      8'sd0,   8'sd60,   8'sd100,  8'sd60,  8'sd0,   -8'sd60,  -8'sd100, -8'sd60,
      8'sd0,   8'sd60,   8'sd100,  8'sd60,  8'sd0,   -8'sd60,  -8'sd100, -8'sd60,
      8'sd0,   8'sd90,   -8'sd20,  -8'sd100, 8'sd30,  8'sd110,  -8'sd40,  -8'sd90,
      8'sd70,  8'sd80,   -8'sd110, 8'sd10,  8'sd120, -8'sd70,  -8'sd50,  8'sd127
   };

   // behavioural model state
   int         m_dl [4];
   int         m_xp, m_yp, m_phase;
   logic [2:0] m_hist;
   logic [1:0] m_found;
   logic       m_vld, m_bit;
   logic       got_vld, got_bit;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_dl[i] = 0;
      m_xp = 0; m_yp = 0; m_phase = 0;
      m_hist = '0; m_found = '0; m_vld = 1'b0; m_bit = 1'b0;
   endtask

   task automatic model_step(input int s);
      int x, y, ones;
      x = (m_dl[3] * s) >>> 2;
      for (int i = 3; i > 0; i--) m_dl[i] = m_dl[i-1];
      m_dl[0] = s;
      y = m_xp + x + (m_yp >>> 1) + (m_yp >>> 3) + (m_yp >>> 5);
      m_xp = x; m_yp = y;
      m_hist = {m_hist[1:0], (y > 0)};
      if (m_hist[1] != m_hist[0]) m_phase = (m_phase < 32) ? m_phase + 1 : m_phase - 1;
      m_phase = m_phase + 8;
      m_vld = 1'b0;
      if (m_phase >= 64) begin
         m_phase = m_phase - 64;
         ones = int'(m_hist[0]) + int'(m_hist[1]) + int'(m_hist[2]);
         m_found = {m_found[0], (ones >= 2)};
         m_vld = 1'b1;
         m_bit = (m_found[1] == m_found[0]);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; smp_vld = 1'b0; smp_in = '0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // present one sample, compare with the model, then idle for gap cycles
   task automatic push(input logic signed [7:0] s, input int gap, input string req);
      @(negedge clk);
      smp_vld = 1'b1; smp_in = s;
      model_step(int'(s));
      @(negedge clk);
      smp_vld = 1'b0;
      got_vld = bit_vld; got_bit = bit_out;
      check(bit_vld === m_vld, req, "bit_vld vs model", int'(bit_vld), int'(m_vld));
      if (m_vld) check(bit_out === m_bit, req, "bit_out vs model", int'(bit_out), int'(m_bit));
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         check(bit_vld === 1'b0, "R9", "bit_vld during idle", int'(bit_vld), 0);
      end
   endtask

   initial begin : p_watchdog
      #(4 * 100000);
      n_err++; n_chk++;
      $display("FAIL R9 watchdog expired: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : p_main
      logic signed [7:0] s;
      // reset state, R1
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(bit_vld === 1'b0, "R1", "bit_vld in reset", int'(bit_vld), 0);
      check(bit_out === 1'b0, "R1", "bit_out in reset", int'(bit_out), 0);
      model_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check(bit_vld === 1'b0, "R1", "bit_vld after release", int'(bit_vld), 0);

      // all zeros: strobe on sample 8 only, slice of zero is 0, output 1 (R4, R5)
      for (int i = 1; i <= 8; i++) begin
         push(8'sd0, 0, "R5");
         check(got_vld === (i == 8), "R5", "zero-input strobe position",
               int'(got_vld), int'(i == 8));
      end
      check(got_bit === 1'b1, "R4", "zero input decoded bit", int'(got_bit), 1);

      // constant positive: edge on sample 5 at phase 32 moves strobe to 9 (R2, R6)
      do_reset();
      for (int i = 1; i <= 17; i++) begin
         push(8'sd100, 2, "R6");
         if (i == 8) check(got_vld === 1'b0, "R2", "no strobe on sample 8", int'(got_vld), 0);
         if (i == 9) begin
            check(got_vld === 1'b1, "R6", "strobe on sample 9", int'(got_vld), 1);
            check(got_bit === 1'b0, "R8", "first decision differs from 0", int'(got_bit), 0);
         end
         if (i == 16) check(got_vld === 1'b0, "R5", "no strobe on sample 16", int'(got_vld), 0);
         if (i == 17) begin
            check(got_vld === 1'b1, "R5", "strobe 8 samples later", int'(got_vld), 1);
            check(got_bit === 1'b1, "R7", "repeated 1 decision", int'(got_bit), 1);
         end
      end

      // table walk: forward, negated with gaps, reversed (R3, R6, R7, R8)
      for (int pass = 0; pass < 3; pass++) begin
         do_reset();
         for (int rep = 0; rep < 3; rep++) begin
            for (int i = 0; i < TAB_N; i++) begin
               if (pass == 1)      s = -WALK_TAB[i];
               else if (pass == 2) s = WALK_TAB[TAB_N-1-i];
               else                s = WALK_TAB[i];
               push(s, (pass == 1) ? (i % 3) : 0, "R3/R7");
            end
         end
      end

      // reset in the middle of a run clears everything (R1)
      rst_n = 1'b0;
      @(negedge clk);
      check(bit_vld === 1'b0, "R1", "bit_vld on mid-run reset", int'(bit_vld), 0);
      check(bit_out === 1'b0, "R1", "bit_out on mid-run reset", int'(bit_out), 0);
      model_reset();
      rst_n = 1'b1;
      for (int i = 1; i <= 8; i++) push(8'sd0, 1, "R1");
      check(got_vld === 1'b1, "R1", "fresh phase after reset", int'(got_vld), 1);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule